// File: doc/BRIEF.md
# Boot Frame Loader with Split Header and Payload CRCs

This block sits behind a byte-wide receive link and turns a stream of boot frames into memory writes. A frame opens with a fixed eight-byte header: a 32-bit load address, a 16-bit byte count and a 16-bit checksum over those six bytes. All header fields are big-endian. That many payload bytes follow, and then a second 16-bit checksum that covers only the payload.

Nothing reaches memory until the header checksum has been confirmed. A bad checksum means the address or the length may be corrupt. The loader then raises a one-cycle error pulse and treats the next byte as the start of a fresh header. When the header is valid, each payload byte is written to the next address, starting at the load address, with a write strobe per byte. After the trailing checksum arrives, the loader gives a one-cycle completion pulse. With that pulse it reports a pass/fail verdict and presents the load address as the execute address, so a boot controller can jump there when the verdict is good.

Top module: `boot_frame_loader`

## Requirements
- R1: After synchronous reset, `wr_en`, `done`, `pass`, `hdr_err` are 0 and `exec_addr` is 0.
- R2: Both checksums are CRC-16 with polynomial 0x1021 and start value 0xFFFF. Bits are processed MSB first, with no final inversion. The received checksum is sent high byte first and must equal the CRC of the covered bytes. For example, payload "123456789" (bytes 0x31..0x39) needs the trailer 0x29, 0xB1.
- R3: For a valid header, payload byte k (counting from 0) produces `wr_en`=1 in the cycle after it is accepted. In that cycle `wr_addr` = (load address + k) mod 2^32 and `wr_data` holds the byte.
- R4: If the header checksum does not match, `hdr_err` pulses for one cycle after the eighth header byte and no write occurs. The next accepted byte is taken as header byte 0.
- R5: One cycle after the second trailer byte is accepted, `done` pulses for one cycle. In that cycle `pass` is 1 exactly when the trailer equals the payload CRC, and `exec_addr` equals the frame's load address. Both values hold until the next `done`.
- R6: A byte count of 0 makes the trailer follow the header directly (expected trailer 0xFFFF), with no writes.
- R7: A byte is accepted only on a clock edge where `in_valid` is 1. Bytes presented while `in_valid` is 0 change nothing, and idle cycles may appear anywhere in a frame.
- R8: Frames may follow back to back. The byte after a trailer, or after a rejected header, begins a new header.
- R9: The address counter wraps modulo 2^32 within a payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this edge |
| in_byte | input | 8 | Received link byte |
| wr_en | output | 1 | Memory write strobe, one per payload byte |
| wr_addr | output | 32 | Write address |
| wr_data | output | 8 | Write data |
| done | output | 1 | One-cycle pulse when a frame's trailer has been checked |
| pass | output | 1 | Payload checksum verdict, valid with `done` and held |
| exec_addr | output | 32 | Execute address (frame load address), updated with `done` |
| hdr_err | output | 1 | One-cycle pulse when a header checksum fails |

## Verification
The assertions assume that every output pulse traces back to a byte accepted on the previous edge, and that no single payload spans more than one frame's writes. This lets consecutive strobes be checked for a step of one in address. The stimulus keeps to this by sending a rejected header alone, never followed by its payload, so the parser's view of frame boundaries stays the same as the bench's. Gaps with random bytes on `in_byte` while `in_valid` is low are mixed with back-to-back bursts. Directed frames cover a zero length, an address that wraps, and the known check string.

// File: rtl/bfl_pkg.sv
package bfl_pkg;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [1:0] {
    BODY_IDLE,
    BODY_DATA,
    BODY_TRL_HI,
    BODY_TRL_LO
  } body_state_t;

  function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                             input logic [7:0]  b);
    logic [15:0] r;
    r = cur;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/bfl_crc16.sv
module bfl_crc16
  import bfl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= CRC_SEED;
    else if (en)    crc <= crc16_step(crc, din);
  end

endmodule

// File: rtl/bfl_hdr.sv
module bfl_hdr #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic [7:0]        din,
  output logic              good,
  output logic              bad,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt
);

  localparam int PAY_W     = ADDR_W + CNT_W;
  localparam int PAY_BYTES = PAY_W / 8;
  localparam int HDR_BYTES = PAY_BYTES + 2;
  localparam int IDX_W     = $clog2(HDR_BYTES);

  logic [IDX_W-1:0] idx;
  logic [PAY_W-1:0] sr;
  logic [7:0]       crc_hi;
  logic [15:0]      crc_q;
  logic             in_pay;
  logic             at_hi;
  logic             at_last;
  logic             match;

  assign in_pay  = idx < IDX_W'(PAY_BYTES);
  assign at_hi   = idx == IDX_W'(PAY_BYTES);
  assign at_last = idx == IDX_W'(HDR_BYTES - 1);
  assign match   = {crc_hi, din} == crc_q;

  bfl_crc16 u_crc (
    .clk (clk),
    .rst (rst),
    .clr (act && at_last),
    .en  (act && in_pay),
    .din (din),
    .crc (crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      sr     <= '0;
      crc_hi <= '0;
    end else if (act) begin
      if (in_pay) sr <= {sr[PAY_W-9:0], din};
      if (at_hi)  crc_hi <= din;
      idx <= at_last ? '0 : idx + 1'b1;
    end
  end

  assign good = act && at_last && match;
  assign bad  = act && at_last && !match;
  assign addr = sr[PAY_W-1:CNT_W];
  assign cnt  = sr[CNT_W-1:0];

endmodule

// File: rtl/bfl_body.sv
module bfl_body
  import bfl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic              act,
  input  logic [7:0]        din,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] exec_addr
);

  body_state_t       st;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  remain;
  logic [7:0]        trl_hi;
  logic [15:0]       crc_q;

  bfl_crc16 u_crc (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .en  (act && st == BODY_DATA),
    .din (din),
    .crc (crc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BODY_IDLE;
      ptr       <= '0;
      base      <= '0;
      remain    <= '0;
      trl_hi    <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      exec_addr <= '0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (start) begin
        ptr    <= start_addr;
        base   <= start_addr;
        remain <= start_cnt;
        st     <= (start_cnt == '0) ? BODY_TRL_HI : BODY_DATA;
      end else if (act) begin
        case (st)
          BODY_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr;
            wr_data <= din;
            ptr     <= ptr + 1'b1;
            remain  <= remain - 1'b1;
            if (remain == CNT_W'(1)) st <= BODY_TRL_HI;
          end
          BODY_TRL_HI: begin
            trl_hi <= din;
            st     <= BODY_TRL_LO;
          end
          BODY_TRL_LO: begin
            done      <= 1'b1;
            pass      <= {trl_hi, din} == crc_q;
            exec_addr <= base;
            st        <= BODY_IDLE;
          end
          default: st <= BODY_IDLE;
        endcase
      end
    end
  end

  assign busy = st != BODY_IDLE;

endmodule

// File: rtl/boot_frame_loader.sv
module boot_frame_loader #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] exec_addr,
  output logic              hdr_err
);

  logic              busy;
  logic              hdr_good;
  logic              hdr_bad;
  logic [ADDR_W-1:0] hdr_addr;
  logic [CNT_W-1:0]  hdr_cnt;

  bfl_hdr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_hdr (
    .clk  (clk),
    .rst  (rst),
    .act  (in_valid && !busy),
    .din  (in_byte),
    .good (hdr_good),
    .bad  (hdr_bad),
    .addr (hdr_addr),
    .cnt  (hdr_cnt)
  );

  bfl_body #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_body (
    .clk        (clk),
    .rst        (rst),
    .start      (hdr_good),
    .start_addr (hdr_addr),
    .start_cnt  (hdr_cnt),
    .act        (in_valid && busy),
    .din        (in_byte),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .done       (done),
    .pass       (pass),
    .exec_addr  (exec_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) hdr_err <= 1'b0;
    else     hdr_err <= hdr_bad;
  end

endmodule

// File: rtl/boot_frame_loader_chk.sv
module boot_frame_loader_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              done,
  input logic [ADDR_W-1:0] exec_addr,
  input logic              hdr_err
);

  // R7: every output event follows an accepted byte
  a_r7_event_needs_byte: assert property (@(posedge clk) disable iff (rst)
    (wr_en || done || hdr_err) |-> $past(in_valid));

  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: execute address moves only with done
  a_r5_exec_with_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(exec_addr) |-> done);

  // R4: a header error never comes with a write and is a single pulse
  a_r4_err_no_write: assert property (@(posedge clk) disable iff (rst)
    hdr_err |-> !wr_en);

  a_r4_err_single: assert property (@(posedge clk) disable iff (rst)
    hdr_err |=> !hdr_err);

  // R3, R9: consecutive writes step the address by one, wrapping
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1);

  // R8: frame end and header rejection never coincide
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(done && hdr_err));

endmodule

bind boot_frame_loader boot_frame_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .done      (done),
  .exec_addr (exec_addr),
  .hdr_err   (hdr_err)
);

// File: tb/boot_frame_loader_bench.sv
module boot_frame_loader_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        wr_en, done, pass, hdr_err;
  logic [31:0] wr_addr, exec_addr;
  logic [7:0]  wr_data;

  always #10 clk = ~clk;

  boot_frame_loader u_boot_frame_loader (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .pass(pass), .exec_addr(exec_addr), .hdr_err(hdr_err)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] ew_addr [4096];
  logic [7:0]  ew_data [4096];
  int          wexp = 0, wi = 0;
  int          ev_kind [512];   // 0 done pass, 1 done fail, 2 header error
  logic [31:0] ev_addr [512];
  int          evn = 0, evi = 0;
  bit          nogap = 1'b0;
  bit          finished = 1'b0;

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x = c;
    for (int j = 0; j < 8; j++) begin
      logic top = x[15];
      x = x << 1;
      if (top ^ b[7-j]) x = x ^ 16'h1021;
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    int gap = nogap ? 0 : int'($urandom % 3);
    for (int g = 0; g < gap; g++) begin
      in_byte = 8'($urandom);   // R7: garbage while not valid
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [31:0] addr, input int cnt,
                            input bit hdr_bad, input bit dat_bad, input bit vec);
    logic [7:0]  h [8];
    logic [15:0] c = 16'hFFFF;
    logic [7:0]  d [64];
    int k;
    h[0] = addr[31:24]; h[1] = addr[23:16]; h[2] = addr[15:8]; h[3] = addr[7:0];
    h[4] = 8'(cnt >> 8); h[5] = 8'(cnt);
    for (int i = 0; i < 6; i++) c = ref_crc(c, h[i]);
    h[6] = c[15:8]; h[7] = c[7:0];
    if (hdr_bad) begin
      k = int'($urandom % 8);
      h[k] = h[k] ^ (8'h01 << ($urandom % 8));
      ev_kind[evn] = 2; ev_addr[evn] = 32'h0; evn++;
      for (int i = 0; i < 8; i++) put(h[i]);
      return;
    end
    c = 16'hFFFF;
    for (int i = 0; i < cnt; i++) begin
      d[i] = vec ? 8'(8'h31 + i) : 8'($urandom);
      c = ref_crc(c, d[i]);
      ew_addr[wexp] = addr + 32'(i);
      ew_data[wexp] = d[i];
      wexp++;
    end
    if (vec) c = 16'h29B1;   // R2: published check value
    if (dat_bad) c = c ^ (16'h0001 << ($urandom % 16));
    ev_kind[evn] = dat_bad ? 1 : 0; ev_addr[evn] = addr; evn++;
    for (int i = 0; i < 8; i++) put(h[i]);
    for (int i = 0; i < cnt; i++) put(d[i]);
    put(c[15:8]);
    put(c[7:0]);
  endtask

  // Monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (wr_en) begin
        if (wi < wexp) begin
          check(wr_addr == ew_addr[wi], "R3", "write address", wr_addr, ew_addr[wi]);
          check(wr_data == ew_data[wi], "R3", "write data", {24'h0, wr_data}, {24'h0, ew_data[wi]});
          wi++;
        end else begin
          check(1'b0, "R4", "unexpected write", wr_addr, 32'h0);
        end
      end
      if (done || hdr_err) begin
        if (evi < evn) begin
          if (ev_kind[evi] == 2) begin
            check(hdr_err && !done, "R4", "header error pulse", {31'h0, hdr_err}, 32'h1);
          end else begin
            check(done && !hdr_err, "R5", "done pulse", {31'h0, done}, 32'h1);
            check(pass == (ev_kind[evi] == 0), "R5", "pass verdict", {31'h0, pass},
                  (ev_kind[evi] == 0) ? 32'h1 : 32'h0);
            check(exec_addr == ev_addr[evi], "R5", "execute address", exec_addr, ev_addr[evi]);
          end
          evi++;
        end else begin
          check(1'b0, "R8", "unexpected event", {30'h0, done, hdr_err}, 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!wr_en, "R1", "wr_en after reset", {31'h0, wr_en}, 32'h0);
    check(!done, "R1", "done after reset", {31'h0, done}, 32'h0);
    check(!pass, "R1", "pass after reset", {31'h0, pass}, 32'h0);
    check(!hdr_err, "R1", "hdr_err after reset", {31'h0, hdr_err}, 32'h0);
    check(exec_addr == 32'h0, "R1", "exec_addr after reset", exec_addr, 32'h0);

    // R2 known check string
    send_frame(32'h1000_0000, 9, 1'b0, 1'b0, 1'b1);
    // R6 zero length
    send_frame(32'h0000_0400, 0, 1'b0, 1'b0, 1'b0);
    // R9 wrap of address
    send_frame(32'hFFFF_FFFE, 4, 1'b0, 1'b0, 1'b0);
    // R4 rejected header, then a good frame
    send_frame(32'h2000_0000, 5, 1'b1, 1'b0, 1'b0);
    send_frame(32'h2000_0000, 5, 1'b0, 1'b0, 1'b0);
    // R5 bad payload checksum
    send_frame(32'h3000_0010, 7, 1'b0, 1'b1, 1'b0);
    // R8 back to back with no gaps
    nogap = 1'b1;
    send_frame(32'h4000_0000, 3, 1'b0, 1'b0, 1'b0);
    send_frame(32'h4000_1000, 2, 1'b1, 1'b0, 1'b0);
    send_frame(32'h4000_2000, 6, 1'b0, 1'b1, 1'b0);
    send_frame(32'h4000_3000, 0, 1'b0, 1'b0, 1'b0);
    nogap = 1'b0;

    // Random frames, R7 gaps included
    for (int f = 0; f < 40; f++) begin
      nogap = ($urandom % 4) == 0;
      send_frame($urandom, int'($urandom % 41), ($urandom % 5) == 0,
                 ($urandom % 5) == 0, 1'b0);
    end
    nogap = 1'b0;

    repeat (5) @(negedge clk);
    finished = 1'b1;
    check(wi == wexp, "R3", "write count", 32'(wi), 32'(wexp));
    check(evi == evn, "R5", "event count", 32'(evi), 32'(evn));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule